// File: doc/BRIEF.md
# Addressed Slave Frame Handler

This block is the frame layer of a small addressed slave on a shared serial line. It sits behind a byte receiver and a byte transmitter and parses frames sent by a single master. A frame opens with a long low period on the line, the break. A sync byte follows, then an identifier byte that carries two protection bits, a two-bit command code and a four-bit address. Some commands add a data byte and a checksum. The block checks the protection bits and the checksum, compares the address with strap inputs and then carries out the command. A Write drives an 8-bit output port. A Read or Read-Change queues a two-byte reply to the transmitter.

Two commands address every node at once. The first is a sleep request, identifier 0x3C with data 0x00. The second is a carrier-toggle request, identifier 0xFE with data 0x00 and a good checksum. The block reports each of them as a single-cycle pulse, so that power and carrier control elsewhere can act on it. Break detection counts bit ticks while the line is held low.

Top module: `pl_slave_frame`

## Requirements
- R1: A frame is only opened after the line has been low for at least BREAK_BITS (default 13) consecutive bit ticks. A frame that follows a shorter low period has no effect.
- R2: After a break, the next byte must be 0x55, otherwise the parser waits for a new break. A byte received with a framing error at any point of a frame also sends the parser back to waiting for a break.
- R3: Identifier bit layout: bit 7 = P1, bit 6 = P0, bits 5:4 = command (01 Write, 00 Read, 10 Read-Change), bits 3:0 = address. P0 must equal b0^b1^b2^b4 and P1 must equal ~(b1^b3^b4^b5). If either check fails, the frame is dropped.
- R4: A Write frame (identifier, data, checksum) whose address equals node_id and whose checksum is correct puts the data byte on pins_out, bit n to output n, one cycle after the checksum byte. A wrong address or a wrong checksum leaves pins_out unchanged. pins_out changes only in the cycle after a received byte.
- R5: A matching Read makes tx_valid rise in the cycle after the identifier byte. The first reply byte is the current input level of pins_in. The second reply byte is the checksum of the identifier and that data byte.
- R6: The data of a matching Read-Change reply holds, for each input, the level seen at its first change since the previous Read or Read-Change. An input that has not changed reports its current level.
- R7: Every matching Read or Read-Change starts a fresh capture window for all eight inputs.
- R8: Identifier 0x3C followed by data 0x00 raises sleep_pulse for exactly one cycle, one cycle after the data byte, whatever the address. The bytes that follow are ignored. A non-zero data byte gives no pulse.
- R9: Identifier 0xFE, data 0x00 and a correct checksum raise freq_pulse for exactly one cycle, one cycle after the checksum byte. A wrong checksum gives no pulse.
- R10: Reset clears pins_out, tx_valid, sleep_pulse and freq_pulse.
- R11: While a reply is pending, tx_valid and tx_byte hold until tx_ready accepts each byte, and received bytes and breaks are ignored. tx_valid falls after the second byte is accepted.
- R12: Checksum = ~(low 8 bits of (a + b) plus the carry out of that sum). For example, 0x14 and 0xFF give 0xEB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_rx | input | 1 | Raw receive line level, used for break counting |
| bit_tick | input | 1 | One pulse per bit time |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_frame_err | input | 1 | Framing error flag for the strobed byte |
| node_id | input | 4 | Address straps |
| pins_in | input | 8 | Input port levels |
| pins_out | output | 8 | Output port, written by Write frames |
| tx_valid | output | 1 | Reply byte available |
| tx_byte | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter accepts the reply byte |
| sleep_pulse | output | 1 | Global sleep command seen |
| freq_pulse | output | 1 | Global carrier-toggle command seen |

## Verification
If the parser state is wrong, the effect shows within one byte time. Either a good Write does not reach pins_out in the cycle after its checksum, or a frame that should be rejected changes the outputs. The directed frames therefore follow every rejection case with an observation of pins_out, tx_valid or the pulses. If the change-capture state is wrong, it only shows in the data byte of the next Read-Change. The bench therefore runs two Read-Changes back to back after a known pulse pattern on the inputs.

// File: rtl/pl_slave_pkg.sv
package pl_slave_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'h55;
  localparam logic [BYTE_W-1:0] SLEEP_ID  = 8'h3C;
  localparam logic [BYTE_W-1:0] TOGGLE_ID = 8'hFE;
  localparam logic [1:0] CMD_WRITE = 2'b01;
  localparam logic [1:0] CMD_READ  = 2'b00;
  localparam logic [1:0] CMD_RCHG  = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE, S_SYNC, S_PID, S_DATA, S_CKSUM, S_RESP_D, S_RESP_C
  } parse_st_t;

  typedef enum logic [1:0] { K_WRITE, K_SLEEP, K_TOGGLE } frame_kind_t;

  function automatic logic [BYTE_W-1:0] fold_sum(input logic [BYTE_W-1:0] a,
                                                  input logic [BYTE_W-1:0] b);
    logic [BYTE_W:0]   s;
    logic [BYTE_W-1:0] r;
    s = {1'b0, a} + {1'b0, b};
    r = s[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, s[BYTE_W]};
    return ~r;
  endfunction

  function automatic logic pid_ok(input logic [BYTE_W-1:0] p);
    return (p[6] == (p[0] ^ p[1] ^ p[2] ^ p[4])) &&
           (p[7] == ~(p[1] ^ p[3] ^ p[4] ^ p[5]));
  endfunction
endpackage

// File: rtl/pl_break_det.sv
module pl_break_det #(
  parameter int BREAK_BITS = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic line_rx,
  input  logic bit_tick,
  output logic brk_seen
);
  localparam int CNT_W = $clog2(BREAK_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BREAK_BITS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BREAK_BITS);

  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      brk_seen <= 1'b0;
    end else begin
      brk_seen <= 1'b0;
      if (line_rx) begin
        low_cnt <= '0;
      end else if (bit_tick && low_cnt != FULL) begin
        low_cnt <= low_cnt + 1'b1;
        if (low_cnt == LAST) brk_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pl_chg_capture.sv
module pl_chg_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] report
);
  logic [WIDTH-1:0] prev;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic seen, held;
    always_ff @(posedge clk) begin
      if (rst) begin
        level[i] <= 1'b0;
        prev[i]  <= 1'b0;
        seen     <= 1'b0;
        held     <= 1'b0;
      end else begin
        level[i] <= pins[i];
        prev[i]  <= level[i];
        if (clr) begin
          seen <= 1'b0;
        end else if (!seen && (level[i] != prev[i])) begin
          seen <= 1'b1;
          held <= level[i];
        end
      end
    end
    assign report[i] = seen ? held : level[i];
  end
endmodule

// File: rtl/pl_slave_frame.sv
module pl_slave_frame
  import pl_slave_pkg::*;
#(
  parameter int BREAK_BITS = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_rx,
  input  logic              bit_tick,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_frame_err,
  input  logic [ADDR_W-1:0] node_id,
  input  logic [BYTE_W-1:0] pins_in,
  output logic [BYTE_W-1:0] pins_out,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_ready,
  output logic              sleep_pulse,
  output logic              freq_pulse
);
  parse_st_t         st;
  frame_kind_t       kind;
  logic [BYTE_W-1:0] pid_q, dat_q, resp_ck;
  logic [BYTE_W-1:0] in_now, in_rep;
  logic              brk, chg_clr, hit, is_rd, is_rc;

  pl_break_det #(.BREAK_BITS(BREAK_BITS)) u_brk (
    .clk(clk), .rst(rst), .line_rx(line_rx), .bit_tick(bit_tick), .brk_seen(brk)
  );

  pl_chg_capture #(.WIDTH(BYTE_W)) u_cap (
    .clk(clk), .rst(rst), .clr(chg_clr), .pins(pins_in),
    .level(in_now), .report(in_rep)
  );

  always_comb begin
    hit     = pid_ok(rx_byte) && (rx_byte[ADDR_W-1:0] == node_id);
    is_rd   = hit && (rx_byte[5:4] == CMD_READ);
    is_rc   = hit && (rx_byte[5:4] == CMD_RCHG);
    chg_clr = (st == S_PID) && rx_valid && !rx_frame_err && !brk && (is_rd || is_rc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      kind        <= K_WRITE;
      pid_q       <= '0;
      dat_q       <= '0;
      resp_ck     <= '0;
      pins_out    <= '0;
      tx_valid    <= 1'b0;
      tx_byte     <= '0;
      sleep_pulse <= 1'b0;
      freq_pulse  <= 1'b0;
    end else begin
      sleep_pulse <= 1'b0;
      freq_pulse  <= 1'b0;
      case (st)
        S_RESP_D: if (tx_ready) begin
          tx_byte <= resp_ck;
          st      <= S_RESP_C;
        end
        S_RESP_C: if (tx_ready) begin
          tx_valid <= 1'b0;
          st       <= S_IDLE;
        end
        default: begin
          if (brk) begin
            st <= S_SYNC;
          end else if (rx_valid && rx_frame_err) begin
            st <= S_IDLE;
          end else if (rx_valid) begin
            case (st)
              S_SYNC: st <= (rx_byte == SYNC_BYTE) ? S_PID : S_IDLE;
              S_PID: begin
                pid_q <= rx_byte;
                st    <= S_IDLE;
                if (!pid_ok(rx_byte)) begin
                  st <= S_IDLE;
                end else if (rx_byte == SLEEP_ID) begin
                  kind <= K_SLEEP;
                  st   <= S_DATA;
                end else if (rx_byte == TOGGLE_ID) begin
                  kind <= K_TOGGLE;
                  st   <= S_DATA;
                end else if (hit && rx_byte[5:4] == CMD_WRITE) begin
                  kind <= K_WRITE;
                  st   <= S_DATA;
                end else if (is_rd || is_rc) begin
                  tx_valid <= 1'b1;
                  tx_byte  <= is_rd ? in_now : in_rep;
                  resp_ck  <= fold_sum(rx_byte, is_rd ? in_now : in_rep);
                  st       <= S_RESP_D;
                end
              end
              S_DATA: begin
                dat_q <= rx_byte;
                if (kind == K_SLEEP) begin
                  sleep_pulse <= (rx_byte == '0);
                  st          <= S_IDLE;
                end else if (kind == K_TOGGLE && rx_byte != '0) begin
                  st <= S_IDLE;
                end else begin
                  st <= S_CKSUM;
                end
              end
              S_CKSUM: begin
                st <= S_IDLE;
                if (rx_byte == fold_sum(pid_q, dat_q)) begin
                  if (kind == K_WRITE) pins_out <= dat_q;
                  if (kind == K_TOGGLE) freq_pulse <= 1'b1;
                end
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pl_slave_frame_chk.sv
module pl_slave_frame_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_valid,
  input logic       rx_frame_err,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte,
  input logic [7:0] pins_out,
  input logic       sleep_pulse,
  input logic       freq_pulse
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pins_out == 8'h00 && !tx_valid && !sleep_pulse && !freq_pulse)); // R10

  AST_OUT_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
    !$stable(pins_out) |-> $past(rx_valid && !rx_frame_err)); // R4

  AST_REPLY_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> $past(rx_valid)); // R5

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte))); // R11

  AST_SLEEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sleep_pulse |=> !sleep_pulse); // R8

  AST_FREQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    freq_pulse |=> !freq_pulse); // R9

  AST_PULSE_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    (sleep_pulse || freq_pulse) |-> ($past(rx_valid) && !(sleep_pulse && freq_pulse))); // R8
endmodule

bind pl_slave_frame pl_slave_frame_chk u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
  .pins_out(pins_out), .sleep_pulse(sleep_pulse), .freq_pulse(freq_pulse)
);

// File: tb/pl_slave_frame_bench.sv
module pl_slave_frame_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_rx = 1'b1, bit_tick = 1'b0;
  logic       rx_valid = 1'b0, rx_frame_err = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_byte = 8'h00, pins_in = 8'h00;
  logic [3:0] node_id = 4'd4;
  logic [7:0] pins_out, tx_byte;
  logic       tx_valid, sleep_pulse, freq_pulse;
  int         errors = 0, checks = 0;

  always #10 clk = ~clk;

  pl_slave_frame u_pl_slave_frame (
    .clk(clk), .rst(rst), .line_rx(line_rx), .bit_tick(bit_tick),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_frame_err(rx_frame_err),
    .node_id(node_id), .pins_in(pins_in), .pins_out(pins_out),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .sleep_pulse(sleep_pulse), .freq_pulse(freq_pulse)
  );

  function automatic logic [7:0] mk_pid(input logic [1:0] cmd, input logic [3:0] id);
    logic [7:0] p;
    p = {2'b00, cmd, id};
    p[6] = p[0] ^ p[1] ^ p[2] ^ p[4];
    p[7] = ~(p[1] ^ p[3] ^ p[4] ^ p[5]);
    return p;
  endfunction

  function automatic logic [7:0] ck(input logic [7:0] a, input logic [7:0] b);
    int s;
    s = int'(a) + int'(b);
    s = (s & 255) + (s >> 8);
    return ~(8'(s));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic send_break(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line_rx = 1'b0; bit_tick = 1'b1;
    end
    @(negedge clk); line_rx = 1'b1; bit_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic fe = 1'b0);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b; rx_frame_err = fe;
    @(negedge clk); rx_valid = 1'b0; rx_frame_err = 1'b0;
  endtask

  task automatic write_frame(input int brk, input logic [7:0] sync, input logic [7:0] pid,
                             input logic [7:0] d, input logic [7:0] c);
    send_break(brk);
    send_byte(sync);
    send_byte(pid);
    send_byte(d);
    send_byte(c);
  endtask

  task automatic read_reply(input string req, input logic [7:0] pid, input logic [7:0] exp_d);
    send_break(13);
    send_byte(8'h55);
    send_byte(pid);
    check({req, " tx_valid"}, {7'd0, tx_valid}, 8'h01);
    check({req, " data"}, tx_byte, exp_d);
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    check({req, " checksum"}, tx_byte, ck(pid, exp_d));
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    check({req, " tx_valid low"}, {7'd0, tx_valid}, 8'h00);
  endtask

  task automatic t_reset;
    check("R10 pins_out", pins_out, 8'h00);
    check("R10 tx_valid", {7'd0, tx_valid}, 8'h00);
    check("R10 pulses", {6'd0, sleep_pulse, freq_pulse}, 8'h00);
    check("R12 checksum example", ck(8'h14, 8'hFF), 8'hEB);
  endtask

  task automatic t_write;
    write_frame(13, 8'h55, mk_pid(2'b01, 4'd4), 8'hA5, ck(mk_pid(2'b01, 4'd4), 8'hA5));
    check("R4 write applied", pins_out, 8'hA5);
    write_frame(13, 8'h55, mk_pid(2'b01, 4'd4), 8'hFF, 8'hEB);
    check("R12 R4 write 0xFF", pins_out, 8'hFF);
    write_frame(13, 8'h55, mk_pid(2'b01, 4'd5), 8'h3C, ck(mk_pid(2'b01, 4'd5), 8'h3C));
    check("R4 other address", pins_out, 8'hFF);
    write_frame(13, 8'h55, mk_pid(2'b01, 4'd4), 8'h3C, 8'h00);
    check("R4 bad checksum", pins_out, 8'hFF);
  endtask

  task automatic t_framing;
    write_frame(12, 8'h55, mk_pid(2'b01, 4'd4), 8'h11, ck(mk_pid(2'b01, 4'd4), 8'h11));
    check("R1 short break", pins_out, 8'hFF);
    write_frame(13, 8'h54, mk_pid(2'b01, 4'd4), 8'h22, ck(mk_pid(2'b01, 4'd4), 8'h22));
    check("R2 bad sync", pins_out, 8'hFF);
    send_break(13); send_byte(8'h55);
    send_byte(mk_pid(2'b01, 4'd4), 1'b1);
    send_byte(8'h33); send_byte(ck(mk_pid(2'b01, 4'd4), 8'h33));
    check("R2 framing error", pins_out, 8'hFF);
    write_frame(13, 8'h55, mk_pid(2'b01, 4'd4) ^ 8'h80, 8'h44, ck(mk_pid(2'b01, 4'd4) ^ 8'h80, 8'h44));
    check("R3 P1 wrong", pins_out, 8'hFF);
    write_frame(13, 8'h55, mk_pid(2'b01, 4'd4) ^ 8'h40, 8'h44, ck(mk_pid(2'b01, 4'd4) ^ 8'h40, 8'h44));
    check("R3 P0 wrong", pins_out, 8'hFF);
  endtask

  task automatic t_read;
    pins_in = 8'h96;
    repeat (4) @(negedge clk);
    send_break(13); send_byte(8'h55); send_byte(mk_pid(2'b00, 4'd4));
    check("R5 data", tx_byte, 8'h96);
    send_break(13);
    send_byte(8'h55);
    check("R11 held valid", {7'd0, tx_valid}, 8'h01);
    check("R11 held byte", tx_byte, 8'h96);
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    check("R5 checksum", tx_byte, ck(mk_pid(2'b00, 4'd4), 8'h96));
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    check("R11 done", {7'd0, tx_valid}, 8'h00);
  endtask

  task automatic t_read_change;
    pins_in = 8'h00;
    repeat (4) @(negedge clk);
    read_reply("R7 clear by read", mk_pid(2'b00, 4'd4), 8'h00);
    pins_in = 8'h8F; repeat (4) @(negedge clk);
    pins_in = 8'h03; repeat (4) @(negedge clk);
    read_reply("R6 first change", mk_pid(2'b10, 4'd4), 8'h8F);
    read_reply("R7 fresh window", mk_pid(2'b10, 4'd4), 8'h03);
  endtask

  task automatic t_sleep;
    send_break(13); send_byte(8'h55); send_byte(8'h3C);
    send_byte(8'h00);
    check("R8 sleep pulse", {7'd0, sleep_pulse}, 8'h01);
    send_byte(ck(8'h3C, 8'h00));
    check("R8 later byte ignored", {6'd0, sleep_pulse, freq_pulse}, 8'h00);
    check("R8 outputs kept", pins_out, 8'hFF);
    send_break(13); send_byte(8'h55); send_byte(8'h3C); send_byte(8'h01);
    check("R8 nonzero data", {7'd0, sleep_pulse}, 8'h00);
  endtask

  task automatic t_freq;
    send_break(13); send_byte(8'h55); send_byte(8'hFE); send_byte(8'h00);
    check("R9 no pulse before checksum", {7'd0, freq_pulse}, 8'h00);
    send_byte(ck(8'hFE, 8'h00));
    check("R9 toggle pulse", {7'd0, freq_pulse}, 8'h01);
    @(negedge clk);
    check("R9 single cycle", {7'd0, freq_pulse}, 8'h00);
    write_frame(13, 8'h55, 8'hFE, 8'h00, 8'h5A);
    check("R9 bad checksum", {7'd0, freq_pulse}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_write;
    t_framing;
    t_read;
    t_read_change;
    t_sleep;
    t_freq;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule